// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block steers instruction fetch for a two-stage integer pipeline (fetch, then execute) whose architecture has exactly one branch delay slot. Every cycle it presents a fetch address and moves the returned word, together with its address and any fetch error, into the execute stage. The execute-stage decoder outside the block reports whether that word is a branch, whether the branch is taken, its target, whether it is an annulling ("likely") branch, whether it faults, and whether it is a return-from-exception. The sequencer chooses the next fetch address from these results and tracks the delay-slot status of each executing instruction from what actually ran.

On a fault it stores a restart address and a branch-delay status bit, flushes the pipeline, vectors fetch to a fixed handler address and masks further traps. The restart address backs up one word when the faulting instruction sits in a delay slot, so a return re-runs the branch. Branches placed in delay slots and branches aimed at their own slot get fixed, repeatable behaviour and never trap.

Top module: `dsps_seq`

## Requirements
- R1: `ex_in_slot_o` is high for an executing instruction exactly when the valid instruction executed in the previous cycle was a branch, taken or not taken.
- R2: With no trap and no return, the fetch address grows by 4 every cycle; a valid taken branch in execute makes the next fetch address its target, so the redirected instruction executes two instructions after the branch.
- R3: The instruction fetched just after a branch always executes, except behind a not-taken annulling branch, where it becomes a bubble (`ex_valid_o` low).
- R4: A trap loads the delay-slot flag of the faulting instruction into `bd_o` and, when that flag is clear, its address into `epc_o`; `cause_o` holds 1 for a fetch bus error, 2 for a misaligned fetch address, 3 for an execute fault.
- R5: When the faulting instruction was in a delay slot, `epc_o` is its address minus 4.
- R6: A valid return-from-exception in execute sets the next fetch address to `epc_o` and clears `masked_o`.
- R7: A fetch error on a delay-slot instruction traps with `bd_o` = 1 and `epc_o` equal to the branch address.
- R8: A branch in a delay slot does not trap; it redirects again, and the instruction after it still has its delay-slot flag set.
- R9: A taken branch whose target is its own delay slot makes the slot instruction execute twice in a row.
- R10: A trap (`exc_take_o`) discards the fetched word, makes the next fetch address 0x1080 and sets `masked_o`; while `masked_o` is high no fault traps and the faulting instruction executes normally.
- R11: After reset the fetch address is 0x1000, the execute stage is a bubble, and `bd_o`, `epc_o`, `cause_o` and `masked_o` are zero.
- R12: A misaligned taken-branch target traps with cause 2 when the fetch from that address reaches execute, and this cause wins over a fetch bus error on the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fetch_addr_o | output | 32 | Address fetched this cycle |
| fetch_word_i | input | 32 | Word returned for `fetch_addr_o` |
| fetch_err_i | input | 1 | Bus error on this fetch |
| ex_valid_o | output | 1 | Execute stage holds a live instruction |
| ex_word_o | output | 32 | Instruction word in execute |
| ex_pc_o | output | 32 | Address of the instruction in execute |
| ex_in_slot_o | output | 1 | Executing instruction is in a delay slot |
| ex_is_branch_i | input | 1 | Decoded: instruction in execute is a branch |
| ex_taken_i | input | 1 | Branch condition result |
| ex_likely_i | input | 1 | Branch annuls its slot when not taken |
| ex_target_i | input | 32 | Branch target address |
| ex_fault_i | input | 1 | Execute-stage fault (e.g. data access) |
| ex_eret_i | input | 1 | Instruction in execute is a return-from-exception |
| exc_take_o | output | 1 | A trap is taken this cycle |
| epc_o | output | 32 | Saved restart address |
| bd_o | output | 1 | Saved branch-delay status |
| cause_o | output | 2 | Saved trap cause |
| masked_o | output | 1 | Traps are masked until return |

## Verification
`exc_take_o` is combinational and is due in the same cycle as the execute-stage inputs that cause it, while the fetch address, the execute-stage outputs and the saved `epc_o`, `bd_o`, `cause_o` and `masked_o` all change on the edge that ends that cycle. The bench drives the decoded execute-stage inputs at the falling edge from the word the block shows, samples one nanosecond later, and compares every output with a bench model that advances by exactly one step per rising edge. Directed programs then check fixed addresses from executed-address logs and saved trap state a set number of cycles later, after the restart state has settled.

// File: rtl/dsps_pkg.sv
package dsps_pkg;

    localparam int unsigned XLEN        = 32;
    localparam int unsigned INSTR_BYTES = 4;
    localparam int unsigned ALIGN_W     = $clog2(INSTR_BYTES);

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_FETCH = 2'd1,
        CAUSE_ALIGN = 2'd2,
        CAUSE_EXEC  = 2'd3
    } cause_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            ex_valid;
        logic [XLEN-1:0] ex_word;
        logic [XLEN-1:0] ex_pc;
        logic            ex_ferr;
        logic            ex_misal;
        logic            ex_slot;
        logic [XLEN-1:0] epc;
        logic            bd;
        cause_e          cause;
        logic            masked;
    } seq_state_t;

endpackage

// File: rtl/dsps_trap_sel.sv
module dsps_trap_sel
    import dsps_pkg::*;
#(
    parameter int unsigned AW    = XLEN,
    parameter int unsigned STEPB = INSTR_BYTES
) (
    input  logic          ex_valid_i,
    input  logic          masked_i,
    input  logic          misal_i,
    input  logic          ferr_i,
    input  logic          xfault_i,
    input  logic          slot_i,
    input  logic [AW-1:0] ex_pc_i,
    output logic          take_o,
    output cause_e        cause_o,
    output logic [AW-1:0] epc_o
);
    localparam logic [AW-1:0] STEP = AW'(STEPB);

    always_comb begin
        // fixed priority: alignment, then bus error, then execute fault
        if (misal_i) begin
            cause_o = CAUSE_ALIGN;
        end else if (ferr_i) begin
            cause_o = CAUSE_FETCH;
        end else if (xfault_i) begin
            cause_o = CAUSE_EXEC;
        end else begin
            cause_o = CAUSE_NONE;
        end
        take_o = ex_valid_i && !masked_i && (cause_o != CAUSE_NONE);
        epc_o  = slot_i ? (ex_pc_i - STEP) : ex_pc_i;
    end

endmodule

// File: rtl/dsps_pc_sel.sv
module dsps_pc_sel
    import dsps_pkg::*;
#(
    parameter int unsigned   AW      = XLEN,
    parameter int unsigned   STEPB   = INSTR_BYTES,
    parameter logic [AW-1:0] EXC_VEC = 32'h0000_1080
) (
    input  logic [AW-1:0] pc_i,
    input  logic          ex_valid_i,
    input  logic          take_i,
    input  logic          eret_i,
    input  logic          br_i,
    input  logic          taken_i,
    input  logic          likely_i,
    input  logic [AW-1:0] target_i,
    input  logic [AW-1:0] epc_i,
    output logic [AW-1:0] next_pc_o,
    output logic          kill_o
);
    localparam logic [AW-1:0] STEP = AW'(STEPB);

    logic [AW-1:0] seq_pc;
    assign seq_pc = pc_i + STEP;

    always_comb begin
        next_pc_o = seq_pc;
        kill_o    = 1'b0;
        if (take_i) begin
            next_pc_o = EXC_VEC;
            kill_o    = 1'b1;
        end else if (ex_valid_i && eret_i) begin
            next_pc_o = epc_i;
            kill_o    = 1'b1;
        end else if (ex_valid_i && br_i && taken_i) begin
            next_pc_o = target_i;
        end else if (ex_valid_i && br_i && likely_i) begin
            // not-taken annulling branch: its slot word becomes a bubble
            kill_o    = 1'b1;
        end
    end

endmodule

// File: rtl/dsps_seq.sv
module dsps_seq
    import dsps_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000,
    parameter logic [XLEN-1:0] EXC_VEC   = 32'h0000_1080
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    output logic [XLEN-1:0] fetch_addr_o,
    input  logic [XLEN-1:0] fetch_word_i,
    input  logic            fetch_err_i,
    output logic            ex_valid_o,
    output logic [XLEN-1:0] ex_word_o,
    output logic [XLEN-1:0] ex_pc_o,
    output logic            ex_in_slot_o,
    input  logic            ex_is_branch_i,
    input  logic            ex_taken_i,
    input  logic            ex_likely_i,
    input  logic [XLEN-1:0] ex_target_i,
    input  logic            ex_fault_i,
    input  logic            ex_eret_i,
    output logic            exc_take_o,
    output logic [XLEN-1:0] epc_o,
    output logic            bd_o,
    output logic [1:0]      cause_o,
    output logic            masked_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

    seq_state_t      state_q, state_d;
    logic            trap_take;
    cause_e          trap_cause;
    logic [XLEN-1:0] trap_epc;
    logic [XLEN-1:0] nxt_pc;
    logic            kill;
    logic            fetch_misal;
    logic            eret_go;

    assign fetch_misal = |state_q.pc[ALIGN_W-1:0];
    assign eret_go     = state_q.ex_valid && ex_eret_i && !trap_take;

    dsps_trap_sel #(
        .AW    (XLEN),
        .STEPB (INSTR_BYTES)
    ) trap_i (
        .ex_valid_i (state_q.ex_valid),
        .masked_i   (state_q.masked),
        .misal_i    (state_q.ex_misal),
        .ferr_i     (state_q.ex_ferr),
        .xfault_i   (ex_fault_i),
        .slot_i     (state_q.ex_slot),
        .ex_pc_i    (state_q.ex_pc),
        .take_o     (trap_take),
        .cause_o    (trap_cause),
        .epc_o      (trap_epc)
    );

    dsps_pc_sel #(
        .AW      (XLEN),
        .STEPB   (INSTR_BYTES),
        .EXC_VEC (EXC_VEC)
    ) pcsel_i (
        .pc_i       (state_q.pc),
        .ex_valid_i (state_q.ex_valid),
        .take_i     (trap_take),
        .eret_i     (ex_eret_i),
        .br_i       (ex_is_branch_i),
        .taken_i    (ex_taken_i),
        .likely_i   (ex_likely_i),
        .target_i   (ex_target_i),
        .epc_i      (state_q.epc),
        .next_pc_o  (nxt_pc),
        .kill_o     (kill)
    );

    always_comb begin
        state_d          = state_q;
        state_d.pc       = nxt_pc;
        state_d.ex_valid = !kill;
        state_d.ex_word  = fetch_word_i;
        state_d.ex_pc    = state_q.pc;
        state_d.ex_ferr  = fetch_err_i;
        state_d.ex_misal = fetch_misal;
        // flag for the next executing instruction: did a branch really run now
        state_d.ex_slot  = state_q.ex_valid && ex_is_branch_i && !trap_take && !ex_eret_i;
        if (trap_take) begin
            state_d.epc    = trap_epc;
            state_d.bd     = state_q.ex_slot;
            state_d.cause  = trap_cause;
            state_d.masked = 1'b1;
        end else if (eret_go) begin
            state_d.masked = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q    <= '0;
            state_q.pc <= RESET_VEC;
        end else begin
            state_q    <= state_d;
        end
    end

    assign fetch_addr_o = state_q.pc;
    assign ex_valid_o   = state_q.ex_valid;
    assign ex_word_o    = state_q.ex_word;
    assign ex_pc_o      = state_q.ex_pc;
    assign ex_in_slot_o = state_q.ex_slot;
    assign exc_take_o   = trap_take;
    assign epc_o        = state_q.epc;
    assign bd_o         = state_q.bd;
    assign cause_o      = state_q.cause;
    assign masked_o     = state_q.masked;

    assert_slot_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ex_valid_o && ex_is_branch_i && !exc_take_o && !ex_eret_i) |=> ex_in_slot_o);

    assert_seq_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!exc_take_o && !(ex_valid_o && (ex_eret_i || (ex_is_branch_i && ex_taken_i))))
        |=> fetch_addr_o == $past(fetch_addr_o) + STEP);

    assert_redirect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!exc_take_o && ex_valid_o && !ex_eret_i && ex_is_branch_i && ex_taken_i)
        |=> fetch_addr_o == $past(ex_target_i));

    assert_slot_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ex_valid_o && ex_is_branch_i && !ex_likely_i && !exc_take_o && !ex_eret_i)
        |=> ex_valid_o);

    assert_restart_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_take_o |=> (bd_o == $past(ex_in_slot_o)) &&
        (epc_o == ($past(ex_in_slot_o) ? $past(ex_pc_o) - STEP : $past(ex_pc_o))));

    assert_return_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ex_valid_o && ex_eret_i && !exc_take_o) |=> (fetch_addr_o == $past(epc_o)) && !masked_o);

    assert_vector_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_take_o |=> (fetch_addr_o == EXC_VEC) && !ex_valid_o && masked_o);

    assert_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        masked_o |-> !exc_take_o);

endmodule

// File: tb/dsps_seq_tb_top.sv
module dsps_seq_tb_top;
    import dsps_pkg::*;

    localparam logic [31:0] RV = 32'h0000_1000;
    localparam logic [31:0] EV = 32'h0000_1080;

    logic        clk = 1'b0;
    logic        rst_ni;
    logic [31:0] fetch_addr_o, fetch_word_i;
    logic        fetch_err_i;
    logic        ex_valid_o, ex_in_slot_o;
    logic [31:0] ex_word_o, ex_pc_o;
    logic        ex_is_branch_i, ex_taken_i, ex_likely_i, ex_fault_i, ex_eret_i;
    logic [31:0] ex_target_i;
    logic        exc_take_o, bd_o, masked_o;
    logic [31:0] epc_o;
    logic [1:0]  cause_o;

    always #5 clk = ~clk;

    dsps_seq dut_i (
        .clk_i(clk), .rst_ni(rst_ni),
        .fetch_addr_o(fetch_addr_o), .fetch_word_i(fetch_word_i), .fetch_err_i(fetch_err_i),
        .ex_valid_o(ex_valid_o), .ex_word_o(ex_word_o), .ex_pc_o(ex_pc_o), .ex_in_slot_o(ex_in_slot_o),
        .ex_is_branch_i(ex_is_branch_i), .ex_taken_i(ex_taken_i), .ex_likely_i(ex_likely_i),
        .ex_target_i(ex_target_i), .ex_fault_i(ex_fault_i), .ex_eret_i(ex_eret_i),
        .exc_take_o(exc_take_o), .epc_o(epc_o), .bd_o(bd_o), .cause_o(cause_o), .masked_o(masked_o)
    );

    // bench-only instruction encoding: [31:28] op (0 plain, 1 branch, 2 annulling branch,
    // 3 faultable load, 4 return), [27] taken, [23:0] target byte address
    logic [31:0] prog [64];
    logic [31:0] bad_addr;
    logic        armed;
    logic        keep_armed;
    int          total = 0;
    int          bad   = 0;
    int          n_trap;
    int          n_log;
    logic [31:0] exec_log [16];

    logic [31:0] m_pc, m_expc, m_epc;
    logic        m_exv, m_ferr, m_mis, m_slot, m_bd, m_mask;
    logic [1:0]  m_cause;

    function automatic logic [31:0] mk(input logic [3:0] op, input logic tk, input logic [31:0] tgt);
        return {op, tk, 3'b000, tgt[23:0]};
    endfunction

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (a[31:8] == 24'h000010) return prog[a[7:2]];
        return mk(4'd1, 1'b1, RV);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive();
        logic [3:0] op;
        op             = ex_word_o[31:28];
        fetch_word_i   = mem_rd(fetch_addr_o);
        fetch_err_i    = (fetch_addr_o == bad_addr);
        ex_is_branch_i = (op == 4'd1) || (op == 4'd2);
        ex_likely_i    = (op == 4'd2);
        ex_taken_i     = ex_word_o[27];
        ex_target_i    = {8'h00, ex_word_o[23:0]};
        ex_fault_i     = (op == 4'd3) && armed;
        ex_eret_i      = (op == 4'd4);
    endtask

    // one cycle: drive at the falling edge, compare, advance the model, wait for next fall
    task automatic cyc();
        logic        tk;
        logic [31:0] npc;
        logic        nexv, nslot;
        drive();
        #1;
        tk = m_exv && !m_mask && (m_mis || m_ferr || ex_fault_i);
        chk("R2 fetch address", fetch_addr_o, m_pc);
        chk("R3 execute valid", {31'd0, ex_valid_o}, {31'd0, m_exv});
        if (m_exv) begin
            chk("R2 execute address", ex_pc_o, m_expc);
            chk("R1 slot flag", {31'd0, ex_in_slot_o}, {31'd0, m_slot});
        end
        chk("R10 trap taken", {31'd0, exc_take_o}, {31'd0, tk});
        chk("R4 saved epc", epc_o, m_epc);
        chk("R4 saved bd", {31'd0, bd_o}, {31'd0, m_bd});
        chk("R4 saved cause", {30'd0, cause_o}, {30'd0, m_cause});
        chk("R10 mask", {31'd0, masked_o}, {31'd0, m_mask});
        if (m_exv && !tk && n_log < 16) begin
            exec_log[n_log] = m_expc;
            n_log++;
        end
        if (tk) begin
            n_trap++;
            m_epc   = m_slot ? m_expc - 32'd4 : m_expc;
            m_bd    = m_slot;
            m_cause = m_mis ? 2'd2 : (m_ferr ? 2'd1 : 2'd3);
            m_mask  = 1'b1;
            npc     = EV;
            nexv    = 1'b0;
            nslot   = 1'b0;
            bad_addr = 32'hFFFF_FFF0;
            if (!keep_armed) armed = 1'b0;
        end else if (m_exv && ex_eret_i) begin
            m_mask = 1'b0;
            npc    = m_epc;
            nexv   = 1'b0;
            nslot  = 1'b0;
        end else begin
            npc   = (m_exv && ex_is_branch_i && ex_taken_i) ? ex_target_i : m_pc + 32'd4;
            nexv  = !(m_exv && ex_is_branch_i && ex_likely_i && !ex_taken_i);
            nslot = m_exv && ex_is_branch_i;
        end
        m_expc = m_pc;
        m_ferr = fetch_err_i;
        m_mis  = |m_pc[1:0];
        m_exv  = nexv;
        m_slot = nslot;
        m_pc   = npc;
        @(negedge clk);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
        prog[32]   = mk(4'd4, 1'b0, 32'h0);
        bad_addr   = 32'hFFFF_FFF0;
        armed      = 1'b0;
        keep_armed = 1'b0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        fetch_word_i = '0; fetch_err_i = 1'b0; ex_is_branch_i = 1'b0; ex_taken_i = 1'b0;
        ex_likely_i = 1'b0; ex_target_i = '0; ex_fault_i = 1'b0; ex_eret_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
        m_pc = RV; m_expc = '0; m_epc = '0; m_exv = 1'b0; m_ferr = 1'b0; m_mis = 1'b0;
        m_slot = 1'b0; m_bd = 1'b0; m_mask = 1'b0; m_cause = 2'd0;
        n_trap = 0; n_log = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));

        // R11: reset state
        clear_prog();
        do_reset();
        #1;
        chk("R11 reset pc", fetch_addr_o, RV);
        chk("R11 reset bubble", {31'd0, ex_valid_o}, 32'd0);
        chk("R11 reset bd", {31'd0, bd_o}, 32'd0);
        chk("R11 reset epc", epc_o, 32'd0);
        chk("R11 reset cause", {30'd0, cause_o}, 32'd0);
        chk("R11 reset mask", {31'd0, masked_o}, 32'd0);
        run(6);

        // R8: branch in a delay slot, load at first target faults
        clear_prog();
        prog[0] = mk(4'd1, 1'b1, 32'h1020);
        prog[1] = mk(4'd1, 1'b1, 32'h1040);
        prog[8] = mk(4'd3, 1'b0, 32'h0);
        armed = 1'b1;
        do_reset();
        run(12);
        chk("R8 epc before first target", epc_o, 32'h101C);
        chk("R8 bd kept after slot branch", {31'd0, bd_o}, 32'd1);
        chk("R4 execute cause", {30'd0, cause_o}, 32'd3);
        chk("R8 first executed", exec_log[0], 32'h1000);
        chk("R8 slot branch executed", exec_log[1], 32'h1004);
        chk("R10 handler at vector", exec_log[2], EV);
        chk("R6 resume at epc", exec_log[3], 32'h101C);

        // R9: branch aimed at its own slot
        clear_prog();
        prog[0] = mk(4'd1, 1'b1, 32'h1004);
        do_reset();
        run(6);
        chk("R9 branch", exec_log[0], 32'h1000);
        chk("R9 slot first run", exec_log[1], 32'h1004);
        chk("R9 slot second run", exec_log[2], 32'h1004);
        chk("R9 then sequential", exec_log[3], 32'h1008);

        // R7: fetch error on the delay-slot word
        clear_prog();
        prog[0] = mk(4'd1, 1'b1, 32'h1040);
        do_reset();
        bad_addr = 32'h1004;
        run(10);
        chk("R7 epc at branch", epc_o, 32'h1000);
        chk("R7 bd set", {31'd0, bd_o}, 32'd1);
        chk("R7 fetch cause", {30'd0, cause_o}, 32'd1);

        // R12: misaligned target, also flagged as bus error
        clear_prog();
        prog[0] = mk(4'd1, 1'b1, 32'h1042);
        do_reset();
        bad_addr = 32'h1042;
        run(8);
        chk("R12 align cause wins", {30'd0, cause_o}, 32'd2);
        chk("R12 epc is misaligned address", epc_o, 32'h1042);
        chk("R12 bd clear", {31'd0, bd_o}, 32'd0);

        // R3: annulling branch not taken, then taken
        clear_prog();
        prog[0] = mk(4'd2, 1'b0, 32'h1040);
        do_reset();
        run(5);
        chk("R3 annulling branch", exec_log[0], 32'h1000);
        chk("R3 slot annulled", exec_log[1], 32'h1008);
        clear_prog();
        prog[0] = mk(4'd2, 1'b1, 32'h1040);
        do_reset();
        run(5);
        chk("R3 taken likely keeps slot", exec_log[1], 32'h1004);
        chk("R2 redirect two later", exec_log[2], 32'h1040);

        // R1: not-taken branch still marks its slot
        clear_prog();
        prog[0] = mk(4'd1, 1'b0, 32'h1040);
        prog[1] = mk(4'd3, 1'b0, 32'h0);
        armed = 1'b1;
        do_reset();
        run(5);
        chk("R1 not taken sets bd", {31'd0, bd_o}, 32'd1);
        chk("R5 epc minus four", epc_o, 32'h1000);

        // R10: fault while masked executes without trapping
        clear_prog();
        prog[0]  = mk(4'd3, 1'b0, 32'h0);
        prog[32] = mk(4'd3, 1'b0, 32'h0);
        prog[33] = mk(4'd4, 1'b0, 32'h0);
        armed = 1'b1;
        keep_armed = 1'b1;
        do_reset();
        run(6);
        chk("R10 single trap while masked", n_trap, 32'd1);
        chk("R10 masked load executed", exec_log[0], EV);
        chk("R6 return executed", exec_log[1], EV + 32'd4);
        chk("R6 unmasked after return", {31'd0, masked_o}, 32'd0);

        // random programs
        clear_prog();
        for (int i = 0; i < 32; i++) begin
            int unsigned r;
            logic [31:0] t;
            logic [3:0]  op;
            r = $urandom_range(0, 9);
            t = 32'h1000 + ($urandom_range(0, 31) << 2);
            op = (r < 4) ? 4'd0 : (r < 6) ? 4'd1 : (r < 7) ? 4'd2 : 4'd3;
            prog[i] = mk(op, 1'($urandom_range(0, 1)), t);
        end
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 49) == 0) armed = 1'b1;
            if ($urandom_range(0, 79) == 0) bad_addr = 32'h1000 + ($urandom_range(0, 35) << 2);
            cyc();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule